// File: doc/BRIEF.md
# Capture/Compare Interrupt Aggregator

This block gathers event strobes from a set of capture/compare channels and from a base timer. It turns them into three level interrupt requests for the CPU interrupt controller and a set of one-cycle DMA request strobes. Each channel strobe leaves a sticky mark in a channel flag register. Two independent enable masks select which flagged channels feed each of two combined channel interrupts. A separate pending bit collects the base timer's reset and overflow events.

A combined interrupt is raised only when a channel flag goes from 0 to 1. Acknowledging an interrupt clears only that interrupt's pending bit and leaves the channel flags untouched. Software must therefore clear a channel's flag by a register write before that channel can raise a combined interrupt again. A small register port gives read and write access to the flags, the two masks and the pending bits. DMA strobes follow the raw source events and do not depend on flags, masks or pending state.

Top module: `ccirq_aggregator`

## Requirements
- R1: A one-cycle high on `ch_evt[i]` sets bit i of the channel flag register (register address 0) from the next clock edge on.
- R2: A high on `tmr_rst_evt` or `tmr_ovf_evt` sets the timer pending bit (bit 2 of the pending register at address 3, driven on `irq_tmr`) at the next clock edge.
- R3: When channel i's flag rises from 0 to 1 and bit i of mask 0 (address 1) is 1, `irq_comb[0]` (pending bit 0) goes to 1 at the same clock edge. A rising flag whose mask 0 bit is 0 does not set it.
- R4: Mask 1 (address 2) drives `irq_comb[1]` (pending bit 1) by the same rule as R3 and independently of mask 0, so one channel event can set both combined pending bits.
- R5: `irq_ack` does not change the channel flag register.
- R6: An event on a channel whose flag is already 1 sets no combined pending bit, while its DMA strobe still fires.
- R7: A register write to the flag register clears each bit written as 0 and leaves each bit written as 1 unchanged. If a channel event and a write of 0 hit the same bit in the same cycle, the bit ends at 1.
- R8: A pending bit is cleared by its acknowledge (`irq_ack[0]`, `irq_ack[1]`, `tmr_ack`) or by a pending register write with that bit 0. A write with that bit 1 leaves it unchanged. A set condition in the same cycle wins over any clear.
- R9: `dma_req[i]` equals `ch_evt[i]` for i below 8, and `dma_req[8]` is high in any cycle where `tmr_rst_evt` or `tmr_ovf_evt` is high, all in the same cycle and regardless of flags, masks or pending bits.
- R10: Both masks are plain read/write registers. `reg_rdata` shows, with no delay, the register picked by `reg_addr` (0 flags, 1 mask 0, 2 mask 1, 3 pending in bits 2:0, upper bits 0).
- R11: While `rst_n` is low, all flags, masks and pending bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_evt | input | 8 | Channel event strobes |
| tmr_rst_evt | input | 1 | Base timer reset event |
| tmr_ovf_evt | input | 1 | Base timer overflow event |
| irq_ack | input | 2 | Acknowledge for the two combined interrupts |
| tmr_ack | input | 1 | Acknowledge for the timer interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_comb | output | 2 | Combined channel interrupt requests |
| irq_tmr | output | 1 | Base timer interrupt request |
| dma_req | output | 9 | DMA request strobes, channels then timer |

## Verification
A flag bit stuck at 1 shows up at the ports in a specific way. Later events on that channel stop raising `irq_comb`, and a flag read at address 0 shows the stale bit one cycle after the clear write. A wrong mask value routes a rising flag to the wrong combined output, which is visible on `irq_comb` one clock after the event. Pending bits that ignore their acknowledge, or that drop a set arriving in the same cycle, differ from the expected level one clock after the acknowledge cycle. DMA strobes are combinational and are compared inside the event cycle itself.

// File: rtl/ccirq_pkg.sv
package ccirq_pkg;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned N_COMB   = 2;
  localparam int unsigned PEND_TMR = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_FLAG = 2'd0,
    SEL_MSK0 = 2'd1,
    SEL_MSK1 = 2'd2,
    SEL_PEND = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ccirq_flag_bank.sv
module ccirq_flag_bank #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] wr_data,
  output logic [NUM_CH-1:0] flag_q,
  output logic [NUM_CH-1:0] rise
);
  logic [NUM_CH-1:0] flag_d;
  logic              flag_en;

  assign rise    = evt & ~flag_q;
  assign flag_en = wr_en | (|evt);

  always_comb begin
    flag_d = flag_q;
    if (wr_en) flag_d = flag_q & wr_data;
    flag_d = flag_d | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end
endmodule

// File: rtl/ccirq_route.sv
module ccirq_route #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] rise,
  input  logic              msk_we,
  input  logic [NUM_CH-1:0] msk_wdata,
  input  logic              pend_we,
  input  logic              pend_wbit,
  input  logic              ack,
  output logic [NUM_CH-1:0] msk_q,
  output logic              pend_q,
  output logic              pend_set
);
  logic pend_d;
  logic pend_clr;

  assign pend_set = |(rise & msk_q);
  assign pend_clr = ack | (pend_we & ~pend_wbit);

  always_comb begin
    pend_d = pend_q;
    if (pend_clr) pend_d = 1'b0;
    if (pend_set) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      msk_q <= '0;
    else if (msk_we) msk_q <= msk_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/ccirq_tmr_src.sv
module ccirq_tmr_src (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_evt,
  input  logic ovf_evt,
  input  logic ack,
  input  logic pend_we,
  input  logic pend_wbit,
  output logic pend_q,
  output logic dma
);
  logic pend_d;

  assign dma = rst_evt | ovf_evt;

  always_comb begin
    pend_d = pend_q;
    if (ack | (pend_we & ~pend_wbit)) pend_d = 1'b0;
    if (dma) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/ccirq_aggregator.sv
module ccirq_aggregator
  import ccirq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH-1:0]          ch_evt,
  input  logic                       tmr_rst_evt,
  input  logic                       tmr_ovf_evt,
  input  logic [ccirq_pkg::N_COMB-1:0] irq_ack,
  input  logic                       tmr_ack,
  input  logic                       reg_we,
  input  logic [ccirq_pkg::ADDR_W-1:0] reg_addr,
  input  logic [NUM_CH-1:0]          reg_wdata,
  output logic [NUM_CH-1:0]          reg_rdata,
  output logic [ccirq_pkg::N_COMB-1:0] irq_comb,
  output logic                       irq_tmr,
  output logic [NUM_CH:0]            dma_req
);
  localparam int unsigned PEND_W = PEND_TMR + 1;

  reg_sel_e          sel;
  logic [NUM_CH-1:0] flag_q;
  logic [NUM_CH-1:0] rise;
  logic [NUM_CH-1:0] msk_q [N_COMB];
  logic [N_COMB-1:0] pend_set;
  logic              pend_we;
  logic              tmr_dma;
  logic [PEND_W-1:0] pend_vec;

  assign sel     = reg_sel_e'(reg_addr);
  assign pend_we = reg_we && (sel == SEL_PEND);

  ccirq_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (ch_evt),
    .wr_en   (reg_we && (sel == SEL_FLAG)),
    .wr_data (reg_wdata),
    .flag_q  (flag_q),
    .rise    (rise)
  );

  for (genvar j = 0; j < N_COMB; j++) begin : g_route
    ccirq_route #(.NUM_CH(NUM_CH)) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (rise),
      .msk_we    (reg_we && (reg_addr == ADDR_W'(j + 1))),
      .msk_wdata (reg_wdata),
      .pend_we   (pend_we),
      .pend_wbit (reg_wdata[j]),
      .ack       (irq_ack[j]),
      .msk_q     (msk_q[j]),
      .pend_q    (irq_comb[j]),
      .pend_set  (pend_set[j])
    );
  end

  ccirq_tmr_src u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_evt   (tmr_rst_evt),
    .ovf_evt   (tmr_ovf_evt),
    .ack       (tmr_ack),
    .pend_we   (pend_we),
    .pend_wbit (reg_wdata[PEND_TMR]),
    .pend_q    (irq_tmr),
    .dma       (tmr_dma)
  );

  assign pend_vec = {irq_tmr, irq_comb};
  assign dma_req  = {tmr_dma, ch_evt};

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_FLAG: reg_rdata = flag_q;
      SEL_MSK0: reg_rdata = msk_q[0];
      SEL_MSK1: reg_rdata = msk_q[1];
      SEL_PEND: reg_rdata[PEND_W-1:0] = pend_vec;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ccirq_aggregator_chk.sv
module ccirq_aggregator_chk #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_evt,
  input logic              tmr_rst_evt,
  input logic              tmr_ovf_evt,
  input logic [1:0]        irq_ack,
  input logic              reg_we,
  input logic [NUM_CH-1:0] flag_q,
  input logic [NUM_CH-1:0] msk0,
  input logic [NUM_CH-1:0] msk1,
  input logic [1:0]        pend_set,
  input logic [1:0]        irq_comb,
  input logic              irq_tmr
);
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_evt) |=> ((flag_q & $past(ch_evt)) == $past(ch_evt))); // R1

  AST_TMR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_rst_evt || tmr_ovf_evt) |=> irq_tmr); // R2

  AST_COMB0_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_comb[0]) |-> $past(|(ch_evt & ~flag_q & msk0))); // R3

  AST_COMB1_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_comb[1]) |-> $past(|(ch_evt & ~flag_q & msk1))); // R4

  AST_ACK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|irq_ack) && !reg_we && (ch_evt == '0)) |=> $stable(flag_q)); // R5

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack[0] && !pend_set[0]) |=> !irq_comb[0]); // R8
endmodule

bind ccirq_aggregator ccirq_aggregator_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ch_evt      (ch_evt),
  .tmr_rst_evt (tmr_rst_evt),
  .tmr_ovf_evt (tmr_ovf_evt),
  .irq_ack     (irq_ack),
  .reg_we      (reg_we),
  .flag_q      (flag_q),
  .msk0        (msk_q[0]),
  .msk1        (msk_q[1]),
  .pend_set    (pend_set),
  .irq_comb    (irq_comb),
  .irq_tmr     (irq_tmr)
);

// File: tb/ccirq_aggregator_tb.sv
module ccirq_aggregator_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ch_evt = '0;
  logic       tmr_rst_evt = 1'b0;
  logic       tmr_ovf_evt = 1'b0;
  logic [1:0] irq_ack = '0;
  logic       tmr_ack = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] irq_comb;
  logic       irq_tmr;
  logic [8:0] dma_req;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ccirq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .ch_evt(ch_evt), .tmr_rst_evt(tmr_rst_evt),
    .tmr_ovf_evt(tmr_ovf_evt), .irq_ack(irq_ack), .tmr_ack(tmr_ack),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_comb(irq_comb), .irq_tmr(irq_tmr),
    .dma_req(dma_req)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_ch(input logic [7:0] v);
    @(negedge clk);
    ch_evt = v;
    #1 check("R9 dma channels", 16'(dma_req), 16'({1'b0, v}));
    @(negedge clk);
    ch_evt = '0;
  endtask

  task automatic ack_comb(input logic [1:0] v);
    @(negedge clk);
    irq_ack = v;
    @(negedge clk);
    irq_ack = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R11 reset regs", 16'(d), 16'h0);
    end
    check("R11 reset irq", 16'({irq_tmr, irq_comb}), 16'h0);
  endtask

  task automatic t_mask_rw;
    logic [7:0] d;
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h3C);
    rd(2'd1, d); check("R10 mask0 readback", 16'(d), 16'h00A5);
    rd(2'd2, d); check("R10 mask1 readback", 16'(d), 16'h003C);
  endtask

  task automatic t_flag_set;
    logic [7:0] d;
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    pulse_ch(8'h05);
    rd(2'd0, d); check("R1 flags set", 16'(d), 16'h0005);
    check("R3 masked off no irq", 16'(irq_comb), 16'h0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_route;
    logic [7:0] d;
    wr(2'd1, 8'h01); wr(2'd2, 8'h03);
    pulse_ch(8'h01);
    check("R4 both combined set", 16'(irq_comb), 16'h3);
    ack_comb(2'b01);
    check("R8 ack clears irq0 only", 16'(irq_comb), 16'h2);
    rd(2'd0, d); check("R5 ack keeps flags", 16'(d), 16'h0001);
    ack_comb(2'b10);
    pulse_ch(8'h01);
    check("R6 no retrigger on set flag", 16'(irq_comb), 16'h0);
    pulse_ch(8'h02);
    check("R3 mask0 bit1 off, R4 mask1 on", 16'(irq_comb), 16'h2);
    ack_comb(2'b11);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_clear;
    logic [7:0] d;
    pulse_ch(8'h03);
    wr(2'd0, 8'hFF);
    rd(2'd0, d); check("R7 write one keeps", 16'(d), 16'h0003);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00; ch_evt = 8'h01;
    @(negedge clk);
    reg_we = 1'b0; ch_evt = '0;
    rd(2'd0, d); check("R7 event wins over clear", 16'(d), 16'h0001);
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R7 write zero clears", 16'(d), 16'h0000);
  endtask

  task automatic t_pend;
    logic [7:0] d;
    wr(2'd1, 8'h10); wr(2'd2, 8'h10);
    pulse_ch(8'h10);
    rd(2'd3, d); check("R8 pending read", 16'(d), 16'h0003);
    wr(2'd3, 8'h02);
    rd(2'd3, d); check("R8 write zero clears bit0 only", 16'(d), 16'h0002);
    wr(2'd0, 8'h00);
    @(negedge clk);
    irq_ack = 2'b10; ch_evt = 8'h10;
    @(negedge clk);
    irq_ack = '0; ch_evt = '0;
    check("R8 set wins over ack", 16'(irq_comb), 16'h3);
    ack_comb(2'b11);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_timer;
    logic [7:0] d;
    @(negedge clk);
    tmr_rst_evt = 1'b1;
    #1 check("R9 dma timer", 16'(dma_req[8]), 16'h1);
    @(negedge clk);
    tmr_rst_evt = 1'b0;
    check("R2 timer reset sets", 16'(irq_tmr), 16'h1);
    rd(2'd3, d); check("R2 pending bit2", 16'(d), 16'h0004);
    @(negedge clk); tmr_ack = 1'b1;
    @(negedge clk); tmr_ack = 1'b0;
    check("R8 timer ack", 16'(irq_tmr), 16'h0);
    @(negedge clk); tmr_ovf_evt = 1'b1;
    @(negedge clk); tmr_ovf_evt = 1'b0;
    check("R2 timer overflow sets", 16'(irq_tmr), 16'h1);
    wr(2'd3, 8'h03);
    check("R8 timer write zero", 16'(irq_tmr), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_mask_rw();
    t_flag_set();
    t_route();
    t_clear();
    t_pend();
    t_timer();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule